// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the software-visible face of a simple system DMA channel. A processor reaches it through a 32-bit word-access port and sees four words: a control and status word, a running memory address, and two general-purpose words. Only the low four address bits are decoded, so the window can sit at any 16-byte offset and is not tied to a page boundary.

The control word gates the interrupt of the attached peripheral, drives a DMA-enable level and a one-cycle reset pulse toward that peripheral, and carries a version field and status bits that software writes cannot change. The running address advances by the byte count of each transfer that the data mover reports. A software write to that word also marks the address as loaded.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, the other three words read zero, and cpu_irq, periph_rst and dma_en are low.
- R2: The word index is bus_addr[3:2]; index 0 is control, 1 is address, 2 and 3 are general words. Address bits above bit 3 and below bit 2 have no effect.
- R3: A control write leaves bits 31:25 and 2:0 unchanged; bits 31:28 always read 4'hA.
- R4: Control bit 0 (pending) equals the periph_irq level of the previous clock edge and cannot be written by software.
- R5: cpu_irq is high exactly when control bit 0 and control bit 4 (interrupt enable) are both set.
- R6: A control write with bit 7 set makes periph_rst high for exactly the one cycle after the write.
- R7: For a control write with bit 7 clear, a set bit 6 (drain) is stored as 0, and an all-zero value stores bit 6 as 1. With bit 7 set, bit 6 is stored as written.
- R8: dma_en equals control bit 9; a write changes it in the same cycle as the stored bit.
- R9: A write to word 1 stores the full value and sets control bit 26 (loaded), which stays set until reset.
- R10: A cycle with xfer_valid high adds xfer_bytes to the address word, wrapping modulo 2^32.
- R11: When xfer_valid and a software write to word 1 fall in the same cycle, the written value is stored and the transfer is dropped.
- R12: A read (bus_sel high, bus_we low) returns the addressed word on bus_rdata in the next cycle; bus_rdata holds otherwise and reads change no state. General words keep all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 3:2 select a word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| xfer_valid | input | 1 | A transfer completed this cycle |
| xfer_bytes | input | LEN_W | Byte count of the reported transfer |
| cpu_irq | output | 1 | Interrupt to the processor |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en | output | 1 | DMA enable level |

## Verification
The two functions that share a cycle are the data mover's transfer report and the processor's write to the address word; both target the same register. The bench drives xfer_valid and a word-1 write on the same clock edge and reads the address back, expecting the written value with no byte count added and the loaded bit set. Random interleaving also puts transfer reports next to address writes and reads, so the model's address is compared after both orders.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
   localparam int unsigned DW = 32;

   // control word bit positions
   localparam int unsigned B_PEND  = 0;
   localparam int unsigned B_IEN   = 4;
   localparam int unsigned B_DRAIN = 6;
   localparam int unsigned B_PRST  = 7;
   localparam int unsigned B_DIR   = 8;
   localparam int unsigned B_DEN   = 9;
   localparam int unsigned B_LOAD  = 26;

   localparam logic [DW-1:0] CTL_KEEP_MASK = 32'hFE00_0007;

   typedef enum logic [1:0] {
      W_CTL  = 2'd0,
      W_ADDR = 2'd1,
      W_GP0  = 2'd2,
      W_GP1  = 2'd3
   } word_e;
endpackage

// File: rtl/chan_ctl_csr.sv
module chan_ctl_csr
   import chan_ctl_pkg::*;
#(
   parameter logic [3:0] VERSION = 4'hA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          periph_irq,
   input  logic          addr_load,
   output logic [DW-1:0] ctl_q,
   output logic          cpu_irq,
   output logic          periph_rst,
   output logic          dma_en
);
   localparam logic [DW-1:0] RESET_VAL = {VERSION, 28'h0};

   logic [DW-1:0] cmd_val;
   logic [DW-1:0] ctl_nxt;

   always_comb begin
      cmd_val = wdata;
      if (!cmd_val[B_PRST]) begin
         if (cmd_val[B_DRAIN])
            cmd_val[B_DRAIN] = 1'b0;
         else if (cmd_val == '0)
            cmd_val[B_DRAIN] = 1'b1;
      end
      ctl_nxt = ctl_q;
      if (wr_en)
         ctl_nxt = (ctl_q & CTL_KEEP_MASK) | (cmd_val & ~CTL_KEEP_MASK);
      ctl_nxt[B_PEND] = periph_irq;
      if (addr_load)
         ctl_nxt[B_LOAD] = 1'b1;
      ctl_nxt[DW-1:DW-4] = VERSION;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= RESET_VAL;
         periph_rst <= 1'b0;
      end else begin
         ctl_q      <= ctl_nxt;
         periph_rst <= wr_en & wdata[B_PRST];
      end
   end

   assign cpu_irq = ctl_q[B_PEND] & ctl_q[B_IEN];
   assign dma_en  = ctl_q[B_DEN];

   // R3: protected bits other than loaded/pending survive a write
   a_r3_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> {ctl_q[27], ctl_q[25], ctl_q[2:1]} ==
                $past({ctl_q[27], ctl_q[25], ctl_q[2:1]}));
   a_r3_version: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[DW-1:DW-4] == VERSION);
   a_r4_pending: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ctl_q[B_PEND] == $past(periph_irq));
   a_r6_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst |-> $past(wr_en && wdata[B_PRST]));
   a_r8_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_en) |-> $past(wr_en && wdata[B_DEN]));
   a_r9_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load |=> ctl_q[B_LOAD]);
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[B_LOAD] |=> ctl_q[B_LOAD]);
endmodule

// File: rtl/chan_ctl_addr.sv
module chan_ctl_addr
   import chan_ctl_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wdata,
   input  logic             xfer_valid,
   input  logic [LEN_W-1:0] xfer_bytes,
   output logic [DW-1:0]    addr_q
);
   logic [DW-1:0] bytes_ext;
   assign bytes_ext = DW'(xfer_bytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (wr_en)
         addr_q <= wdata;
      else if (xfer_valid)
         addr_q <= addr_q + bytes_ext;
   end

   a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !wr_en) |=> addr_q == $past(addr_q) + $past(bytes_ext));
   a_r11_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> addr_q == $past(wdata));
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_valid && !wr_en) |=> $stable(addr_q));
endmodule

// File: rtl/chan_ctl_gpreg.sv
module chan_ctl_gpreg
   import chan_ctl_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= wdata;
   end

   a_r12_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs
   import chan_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned LEN_W   = 16,
   parameter logic [3:0]  VERSION = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              periph_irq,
   input  logic              xfer_valid,
   input  logic [LEN_W-1:0]  xfer_bytes,
   output logic              cpu_irq,
   output logic              periph_rst,
   output logic              dma_en
);
   localparam int unsigned N_GP = 2;

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W must be at least 4");
   end
   if (LEN_W < 1 || LEN_W > DW) begin : g_bad_len_w
      $error("LEN_W must lie in 1..32");
   end

   word_e         word;
   logic          wr, rd;
   logic          unused_addr;
   logic [DW-1:0] ctl_q, addr_q;
   logic [DW-1:0] gp_q [N_GP];
   logic [DW-1:0] rd_mux;

   assign word        = word_e'(bus_addr[3:2]);
   assign wr          = bus_sel & bus_we;
   assign rd          = bus_sel & ~bus_we;
   assign unused_addr = ^bus_addr;

   chan_ctl_csr #(.VERSION(VERSION)) csr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr && word == W_CTL),
      .wdata      (bus_wdata),
      .periph_irq (periph_irq),
      .addr_load  (wr && word == W_ADDR),
      .ctl_q      (ctl_q),
      .cpu_irq    (cpu_irq),
      .periph_rst (periph_rst),
      .dma_en     (dma_en)
   );

   chan_ctl_addr #(.LEN_W(LEN_W)) addr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr && word == W_ADDR),
      .wdata      (bus_wdata),
      .xfer_valid (xfer_valid),
      .xfer_bytes (xfer_bytes),
      .addr_q     (addr_q)
   );

   for (genvar gi = 0; gi < N_GP; gi++) begin : g_gp
      chan_ctl_gpreg gp_i (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr && word == word_e'(gi + 2)),
         .wdata (bus_wdata),
         .q     (gp_q[gi])
      );
   end

   always_comb begin
      unique case (word)
         W_CTL:   rd_mux = ctl_q;
         W_ADDR:  rd_mux = addr_q;
         W_GP0:   rd_mux = gp_q[0];
         default: rd_mux = gp_q[1];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (rd)
         bus_rdata <= rd_mux;
   end

   a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(bus_rdata));
   a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> $past(periph_irq));
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_rst && !$past(wr && bus_wdata[B_PRST])) |-> 1'b0);
endmodule

// File: tb/chan_ctl_regs_tb.sv
`timescale 1ns/1ps
module chan_ctl_regs_tb_top;
   localparam int ADDR_W = 12;
   localparam int LEN_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              periph_irq = 1'b0;
   logic              xfer_valid = 1'b0;
   logic [LEN_W-1:0]  xfer_bytes = '0;
   logic              cpu_irq, periph_rst, dma_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [31:0] m_ctl, m_addr;
   logic [31:0] m_gp [2];

   always #10 clk = ~clk;   // 50 MHz

   chan_ctl_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .periph_irq(periph_irq), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
      .cpu_irq(cpu_irq), .periph_rst(periph_rst), .dma_en(dma_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] f_ctl(input logic [31:0] old, input logic [31:0] val,
                                         input logic irq);
      logic [31:0] v, n;
      v = val;
      if (!v[7]) begin
         if (v[6]) v[6] = 1'b0;
         else if (v == 32'h0) v[6] = 1'b1;
      end
      n = (old & 32'hFE00_0007) | (v & ~32'hFE00_0007);
      n[31:28] = 4'hA;
      n[0] = irq;
      return n;
   endfunction

   function automatic logic [ADDR_W-1:0] mk_addr(input int w);
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom);   // R2: stray bits must not matter
      a[3:2] = 2'(w);
      return a;
   endfunction

   function automatic logic [31:0] model_word(input int w);
      case (w)
         0: return m_ctl;
         1: return m_addr;
         2: return m_gp[0];
         default: return m_gp[1];
      endcase
   endfunction

   task automatic bus_write(input int w, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(w); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      case (w)
         0: m_ctl = f_ctl(m_ctl, d, periph_irq);
         1: begin m_addr = d; m_ctl[26] = 1'b1; end
         2: m_gp[0] = d;
         default: m_gp[1] = d;
      endcase
      check("R6 pulse", 32'(periph_rst), 32'((w == 0) && d[7]));
      check("R8 dma_en", 32'(dma_en), 32'(m_ctl[9]));
      check("R5 cpu_irq", 32'(cpu_irq), 32'(m_ctl[0] & m_ctl[4]));
      @(negedge clk);
      check("R6 pulse width", 32'(periph_rst), 32'h0);
   endtask

   task automatic bus_read(input int w, input string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = mk_addr(w);
      @(negedge clk);
      bus_sel = 1'b0;
      check(req, bus_rdata, model_word(w));
      @(negedge clk);
      check("R12 rdata hold", bus_rdata, model_word(w));
   endtask

   task automatic report_xfer(input logic [LEN_W-1:0] n);
      @(negedge clk);
      xfer_valid = 1'b1; xfer_bytes = n;
      @(negedge clk);
      xfer_valid = 1'b0;
      m_addr = m_addr + 32'(n);
   endtask

   task automatic set_irq(input logic lvl);
      @(negedge clk);
      periph_irq = lvl;
      @(negedge clk);
      m_ctl[0] = lvl;
      check("R5 cpu_irq", 32'(cpu_irq), 32'(lvl & m_ctl[4]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_ctl = 32'hA000_0000; m_addr = '0; m_gp[0] = '0; m_gp[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 cpu_irq", 32'(cpu_irq), 0);
      check("R1 periph_rst", 32'(periph_rst), 0);
      check("R1 dma_en", 32'(dma_en), 0);
      for (int w = 0; w < 4; w++) bus_read(w, "R1 reset word");

      // R7 all-zero write sets drain; drain-set write clears it
      bus_write(0, 32'h0);
      bus_read(0, "R7 zero write");
      check("R7 drain set", 32'(m_ctl[6]), 1);
      bus_write(0, 32'h0000_0040);
      bus_read(0, "R7 drain clears");
      // R7 with reset bit set: drain stored as written; R6 pulse
      bus_write(0, 32'h0000_00C0);
      bus_read(0, "R7 drain with reset");
      // R3 protected bits: write all ones
      bus_write(0, 32'hFFFF_FFFF);
      bus_read(0, "R3 keep mask");
      // R5 gate: enable on, irq toggles
      bus_write(0, 32'h0000_0210);
      set_irq(1'b1);
      bus_read(0, "R4 pending set");
      set_irq(1'b0);
      bus_read(0, "R4 pending clear");
      // R4 software cannot set pending
      bus_write(0, 32'h0000_0011);
      bus_read(0, "R4 sw pending");
      // R9 loaded bit
      bus_write(1, 32'hFFFF_FFF0);
      bus_read(0, "R9 loaded");
      // R10 wrap
      report_xfer(16'h0020);
      bus_read(1, "R10 wrap");
      // R11 simultaneous write and transfer
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(1); bus_wdata = 32'h1234_5678;
      xfer_valid = 1'b1; xfer_bytes = 16'h0100;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; xfer_valid = 1'b0;
      m_addr = 32'h1234_5678;
      bus_read(1, "R11 sw wins");
      // R12 general words
      bus_write(2, 32'hDEAD_BEEF);
      bus_write(3, 32'h0BAD_F00D);
      bus_read(2, "R12 gp0");
      bus_read(3, "R12 gp1");
      // R10 R2 R8 random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom_range(0, 4);
         case (op)
            0: begin
               int w;
               logic [31:0] d;
               w = $urandom_range(0, 3);
               d = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom;
               bus_write(w, d);
            end
            1: bus_read($urandom_range(0, 3), "R2 R12 random read");
            2: report_xfer(LEN_W'($urandom));
            3: set_irq(~periph_irq);
            default: bus_read(0, "R3 R4 random ctl");
         endcase
      end
      bus_read(1, "R10 final addr");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule